// File: doc/BRIEF.md
# Single-Wire Debug Monitor Serial Port

This block is the line interface of a debug monitor that talks to a host over one shared wire. The wire is idle high and carries frames with a low start bit, eight data bits sent least significant bit first, and a high stop bit. Both directions use the same bit period, a fixed number of system clock cycles per bit (`CLKS_PER_BIT`, 1024 by default). The block drives the wire only while it is sending. For the rest of the time the wire belongs to the host, and an external pull-up holds it high.

After reset the first eight correctly framed bytes from the host are taken as a security sequence. The comparison of that sequence against a key happens elsewhere and arrives here as the `key_ok` flag, which is captured when the eighth byte lands. The block then sends ten bit times of low level to tell the host it is ready. From that point the monitor can send bytes through a simple start/ready handshake. If the host sends ten low bit times with no stop bit, the block reports it on a break strobe. It then answers by driving the wire high for two bit times, followed by ten low bit times.

Received bytes appear on `rx_data` with a one-cycle `rx_valid` strobe. A break from the host pulses `rx_break` instead.

Top module: `swmon_link`

## Requirements
- R1: While and directly after `rst`, `pin_oe`, `tx_busy`, `tx_ready`, `rx_valid`, `rx_break`, `cmd_ready` and `sec_unlocked` are all 0.
- R2: A host frame (low start bit, eight data bits LSB first, high stop bit, each bit `CLKS_PER_BIT` cycles) gives exactly one one-cycle `rx_valid` pulse, with `rx_data` equal to the byte.
- R3: A low pulse shorter than half a bit period produces neither `rx_valid` nor `rx_break`, because the line is high at the mid-start sample.
- R4: Ten consecutive low bit times (start, eight zero data bits, low stop position) give one `rx_break` pulse and no `rx_valid`.
- R5: `cmd_ready` stays 0 until eight valid bytes have arrived after reset and the ready break has finished, and then stays 1. `sec_unlocked` takes the value of `key_ok` at the eighth byte and keeps it until reset.
- R6: Once the eighth security byte is received, the block drives the line low for exactly ten bit periods with `pin_oe` high, and then releases it.
- R7: When `cmd_ready` is 1, a break from the host is answered by driving the line. The block begins driving at most a few cycles after the mid-point of the tenth low bit. It drives high for two bit periods, then low for ten bit periods, and then `pin_oe` falls. The whole answer is exactly twelve bit periods.
- R8: A byte accepted through `tx_start` while `tx_ready` is 1 raises `pin_oe` on the next clock edge. The block then sends the low start bit, the eight data bits LSB first and the high stop bit, each for `CLKS_PER_BIT` cycles, and holds `tx_busy` high until the stop bit ends.
- R9: `tx_ready` is 0 during the security phase, the ready break, a break answer, an active reception and any transmission. A `tx_start` seen while `tx_ready` is 0 is ignored, and `pin_oe` stays 0.
- R10: The receiver ignores the pin while the block drives it. Its own transmitted frames and breaks never produce `rx_valid` or `rx_break`.
- R11: A frame whose stop position is low while its data bits are not all zero produces neither strobe, and it is not counted as a security byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | 1 | Level sensed on the shared wire |
| pin_out | output | 1 | Level driven onto the wire when enabled |
| pin_oe | output | 1 | Drive enable for the wire |
| key_ok | input | 1 | External security verdict, captured at the eighth byte |
| rx_data | output | 8 | Last correctly framed received byte |
| rx_valid | output | 1 | One-cycle strobe for a new byte |
| rx_break | output | 1 | One-cycle strobe for a break from the host |
| tx_data | input | 8 | Byte to send |
| tx_start | input | 1 | Request to send `tx_data` |
| tx_ready | output | 1 | A request is accepted in this cycle |
| tx_busy | output | 1 | A frame, ready break or break answer is on the wire |
| cmd_ready | output | 1 | Security phase and ready break are complete |
| sec_unlocked | output | 1 | Captured security verdict |

## Verification
Some properties are checked on every cycle. The engine is never started while it is already sending. Strobes never arrive while the block owns the line. Each output bit stays steady between bit ticks. `rx_valid` and `rx_break` are single-cycle and mutually exclusive. `cmd_ready` never drops once set. Other behaviour can only be shown by the bench scenarios, because it depends on a whole frame on the wire. This covers the exact bit pattern and length of transmitted frames, the ready break and the break answer. It also covers the moment the answer starts relative to the host's break, the counting of eight security bytes, the rejection of glitches and framing errors, and the loopback blindness.

// File: rtl/swmon_pkg.sv
package swmon_pkg;

    localparam int DATA_W     = 8;
    localparam int HOLD_BITS  = 2;
    localparam int BREAK_BITS = 10;
    localparam int FRAME_MAX  = HOLD_BITS + BREAK_BITS;
    localparam int LEN_W      = $clog2(FRAME_MAX + 1);

    typedef struct packed {
        logic [FRAME_MAX-1:0] bits;
        logic [LEN_W-1:0]     len;
    } tx_req_t;

    typedef enum logic [1:0] {
        SEQ_SECURE,
        SEQ_ANNOUNCE,
        SEQ_COMMAND,
        SEQ_ANSWER
    } seq_state_t;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_START,
        RX_BITS
    } rx_state_t;

    function automatic tx_req_t byte_frame(input logic [DATA_W-1:0] d);
        tx_req_t r;
        r.bits = '0;
        r.bits[DATA_W+1:0] = {1'b1, d, 1'b0};
        r.len  = LEN_W'(DATA_W + 2);
        return r;
    endfunction

    function automatic tx_req_t break_frame();
        tx_req_t r;
        r.bits = '0;
        r.len  = LEN_W'(BREAK_BITS);
        return r;
    endfunction

    function automatic tx_req_t answer_frame();
        tx_req_t r;
        r.bits = {{BREAK_BITS{1'b0}}, {HOLD_BITS{1'b1}}};
        r.len  = LEN_W'(FRAME_MAX);
        return r;
    endfunction

endpackage

// File: rtl/swmon_bit_timer.sv
module swmon_bit_timer #(
    parameter int PERIOD = 1024
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic restart,
    input  logic half,
    output logic tick
);
    localparam int CW = (PERIOD > 2) ? $clog2(PERIOD) : 1;
    localparam logic [CW-1:0] FULL_LOAD = CW'(PERIOD - 1);
    localparam logic [CW-1:0] HALF_LOAD = CW'(PERIOD / 2 - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (restart) begin
            cnt <= half ? HALF_LOAD : FULL_LOAD;
        end else if (run) begin
            if (cnt == '0) begin
                cnt <= FULL_LOAD;
            end else begin
                cnt <= cnt - 1'b1;
            end
        end
    end

    assign tick = run && !restart && (cnt == '0);

endmodule

// File: rtl/swmon_tx_engine.sv
module swmon_tx_engine
    import swmon_pkg::*;
#(
    parameter int CLKS_PER_BIT = 1024
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    start,
    input  tx_req_t req,
    output logic    busy,
    output logic    line_out,
    output logic    line_oe
);
    logic [FRAME_MAX-1:0] shreg;
    logic [LEN_W-1:0]     left;
    logic                 tick;

    swmon_bit_timer #(.PERIOD(CLKS_PER_BIT)) i_timer (
        .clk     (clk),
        .rst     (rst),
        .run     (busy),
        .restart (start && !busy),
        .half    (1'b0),
        .tick    (tick)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            shreg <= '1;
            left  <= '0;
        end else if (!busy) begin
            if (start) begin
                busy  <= 1'b1;
                shreg <= req.bits;
                left  <= req.len;
            end
        end else if (tick) begin
            shreg <= {1'b1, shreg[FRAME_MAX-1:1]};
            left  <= left - 1'b1;
            if (left == LEN_W'(1)) begin
                busy <= 1'b0;
            end
        end
    end

    assign line_out = shreg[0];
    assign line_oe  = busy;

    AST_HOLD_BIT: assert property (@(posedge clk) disable iff (rst)
        busy && !tick |=> $stable(line_out)); // R8

    AST_START_LEN: assert property (@(posedge clk) disable iff (rst)
        start && !busy |-> req.len != '0); // R8

endmodule

// File: rtl/swmon_rx.sv
module swmon_rx
    import swmon_pkg::*;
#(
    parameter int CLKS_PER_BIT = 1024
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              line_in,
    input  logic              line_owned,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              rx_break,
    output logic              rx_active
);
    localparam int IDX_W = $clog2(DATA_W + 1);

    logic              sync_a, sync_b, prev_lvl;
    logic [1:0]        own_hist;
    logic              blind, level, fall, tick;
    rx_state_t         state;
    logic [IDX_W-1:0]  idx;
    logic [DATA_W-1:0] shreg;

    assign blind = line_owned | (|own_hist);
    assign level = blind ? 1'b1 : sync_b;
    assign fall  = prev_lvl & ~level;

    swmon_bit_timer #(.PERIOD(CLKS_PER_BIT)) i_timer (
        .clk     (clk),
        .rst     (rst),
        .run     (state != RX_IDLE),
        .restart ((state == RX_IDLE) && fall),
        .half    (1'b1),
        .tick    (tick)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_a   <= 1'b1;
            sync_b   <= 1'b1;
            prev_lvl <= 1'b1;
            own_hist <= '0;
            state    <= RX_IDLE;
            idx      <= '0;
            shreg    <= '0;
            rx_data  <= '0;
            rx_valid <= 1'b0;
            rx_break <= 1'b0;
        end else begin
            sync_a   <= line_in;
            sync_b   <= sync_a;
            own_hist <= {own_hist[0], line_owned};
            prev_lvl <= level;
            rx_valid <= 1'b0;
            rx_break <= 1'b0;
            case (state)
                RX_IDLE: begin
                    if (fall) begin
                        state <= RX_START;
                    end
                end
                RX_START: begin
                    if (blind) begin
                        state <= RX_IDLE;
                    end else if (tick) begin
                        if (level) begin
                            state <= RX_IDLE;
                        end else begin
                            state <= RX_BITS;
                            idx   <= '0;
                        end
                    end
                end
                RX_BITS: begin
                    if (blind) begin
                        state <= RX_IDLE;
                    end else if (tick) begin
                        if (idx < IDX_W'(DATA_W)) begin
                            shreg <= {level, shreg[DATA_W-1:1]};
                            idx   <= idx + 1'b1;
                        end else begin
                            state <= RX_IDLE;
                            if (level) begin
                                rx_valid <= 1'b1;
                                rx_data  <= shreg;
                            end else if (shreg == '0) begin
                                rx_break <= 1'b1;
                            end
                        end
                    end
                end
                default: state <= RX_IDLE;
            endcase
        end
    end

    assign rx_active = (state != RX_IDLE);

    AST_ONE_CYCLE_BYTE: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid); // R2

    AST_BREAK_NOT_BYTE: assert property (@(posedge clk) disable iff (rst)
        !(rx_valid && rx_break)); // R4

endmodule

// File: rtl/swmon_seq.sv
module swmon_seq
    import swmon_pkg::*;
#(
    parameter int SEC_COUNT = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_valid,
    input  logic              rx_break,
    input  logic              rx_active,
    input  logic              key_ok,
    input  logic              eng_busy,
    input  logic              host_start,
    input  logic [DATA_W-1:0] host_data,
    output logic              eng_start,
    output tx_req_t           eng_req,
    output logic              host_ready,
    output logic              cmd_ready,
    output logic              sec_unlocked
);
    localparam int CW = $clog2(SEC_COUNT + 1);

    seq_state_t    state;
    logic [CW-1:0] got;

    assign host_ready = (state == SEQ_COMMAND) && !eng_busy && !rx_active;
    assign cmd_ready  = (state == SEQ_COMMAND) || (state == SEQ_ANSWER);

    always_comb begin
        eng_start = 1'b0;
        eng_req   = byte_frame(host_data);
        case (state)
            SEQ_SECURE: begin
                if (rx_valid && got == CW'(SEC_COUNT - 1)) begin
                    eng_start = 1'b1;
                    eng_req   = break_frame();
                end
            end
            SEQ_COMMAND: begin
                if (rx_break && !eng_busy) begin
                    eng_start = 1'b1;
                    eng_req   = answer_frame();
                end else if (host_start && host_ready) begin
                    eng_start = 1'b1;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state        <= SEQ_SECURE;
            got          <= '0;
            sec_unlocked <= 1'b0;
        end else begin
            case (state)
                SEQ_SECURE: begin
                    if (rx_valid) begin
                        got <= got + 1'b1;
                        if (got == CW'(SEC_COUNT - 1)) begin
                            sec_unlocked <= key_ok;
                            state        <= SEQ_ANNOUNCE;
                        end
                    end
                end
                SEQ_ANNOUNCE: if (!eng_busy) state <= SEQ_COMMAND;
                SEQ_COMMAND:  if (rx_break && !eng_busy) state <= SEQ_ANSWER;
                SEQ_ANSWER:   if (!eng_busy) state <= SEQ_COMMAND;
                default:      state <= SEQ_SECURE;
            endcase
        end
    end

    AST_START_IDLE: assert property (@(posedge clk) disable iff (rst)
        eng_start |-> !eng_busy); // R9

    AST_READY_STICKY: assert property (@(posedge clk) disable iff (rst)
        cmd_ready |=> cmd_ready); // R5

    AST_UNLOCK_HELD: assert property (@(posedge clk) disable iff (rst)
        cmd_ready |=> $stable(sec_unlocked)); // R5

endmodule

// File: rtl/swmon_link.sv
module swmon_link
    import swmon_pkg::*;
#(
    parameter int CLKS_PER_BIT = 1024,
    parameter int SEC_COUNT    = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pin_in,
    output logic              pin_out,
    output logic              pin_oe,
    input  logic              key_ok,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              rx_break,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_start,
    output logic              tx_ready,
    output logic              tx_busy,
    output logic              cmd_ready,
    output logic              sec_unlocked
);
    logic    eng_start;
    tx_req_t eng_req;
    logic    rx_active;

    swmon_rx #(.CLKS_PER_BIT(CLKS_PER_BIT)) i_rx (
        .clk        (clk),
        .rst        (rst),
        .line_in    (pin_in),
        .line_owned (pin_oe),
        .rx_data    (rx_data),
        .rx_valid   (rx_valid),
        .rx_break   (rx_break),
        .rx_active  (rx_active)
    );

    swmon_seq #(.SEC_COUNT(SEC_COUNT)) i_seq (
        .clk          (clk),
        .rst          (rst),
        .rx_valid     (rx_valid),
        .rx_break     (rx_break),
        .rx_active    (rx_active),
        .key_ok       (key_ok),
        .eng_busy     (tx_busy),
        .host_start   (tx_start),
        .host_data    (tx_data),
        .eng_start    (eng_start),
        .eng_req      (eng_req),
        .host_ready   (tx_ready),
        .cmd_ready    (cmd_ready),
        .sec_unlocked (sec_unlocked)
    );

    swmon_tx_engine #(.CLKS_PER_BIT(CLKS_PER_BIT)) i_tx (
        .clk      (clk),
        .rst      (rst),
        .start    (eng_start),
        .req      (eng_req),
        .busy     (tx_busy),
        .line_out (pin_out),
        .line_oe  (pin_oe)
    );

    AST_RX_QUIET: assert property (@(posedge clk) disable iff (rst)
        pin_oe |-> !rx_valid && !rx_break); // R10

    AST_READY_NEEDS_IDLE: assert property (@(posedge clk) disable iff (rst)
        tx_ready |-> !pin_oe && cmd_ready); // R9

endmodule

// File: tb/test_swmon_link.sv
module test_swmon_link;
    localparam int P = 16;
    localparam logic [7:0] SEC_VEC [8] = '{8'h3C, 8'h00, 8'hFF, 8'h81,
                                           8'h7E, 8'h55, 8'hAA, 8'h01};
    localparam logic [7:0] TX_VEC  [2] = '{8'hA5, 8'h80};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic host_level = 1'b1;
    logic key_ok = 1'b0;
    logic [7:0] tx_data = '0;
    logic tx_start = 1'b0;
    logic pin_in, pin_out, pin_oe, rx_valid, rx_break, tx_ready, tx_busy;
    logic cmd_ready, sec_unlocked;
    logic [7:0] rx_data;

    int n_checks = 0;
    int n_fail = 0;
    int valid_cnt = 0;
    int brk_cnt = 0;
    logic [7:0] last_data = '0;

    always #5 clk = ~clk;

    assign pin_in = pin_oe ? pin_out : host_level;

    swmon_link #(.CLKS_PER_BIT(P), .SEC_COUNT(8)) i_swmon_link (
        .clk(clk), .rst(rst), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
        .key_ok(key_ok), .rx_data(rx_data), .rx_valid(rx_valid), .rx_break(rx_break),
        .tx_data(tx_data), .tx_start(tx_start), .tx_ready(tx_ready), .tx_busy(tx_busy),
        .cmd_ready(cmd_ready), .sec_unlocked(sec_unlocked)
    );

    always @(negedge clk) begin
        if (!rst && rx_valid) begin
            valid_cnt <= valid_cnt + 1;
            last_data <= rx_data;
        end
        if (!rst && rx_break) brk_cnt <= brk_cnt + 1;
    end

    task automatic chk(input string req, input int actual, input int expected);
        n_checks++;
        if (actual != expected) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, actual, expected);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_fail, n_checks);
        $finish;
    endtask

    task automatic send_bits(input logic [11:0] bits, input int n);
        for (int i = 0; i < n; i++) begin
            host_level = bits[i];
            repeat (P) @(posedge clk);
            #1;
        end
        host_level = 1'b1;
    endtask

    task automatic send_byte(input logic [7:0] d);
        send_bits({2'b11, 1'b1, d, 1'b0}, 12);
    endtask

    task automatic capture(input int nbits, output logic [11:0] got,
                           output int waited, output logic len_ok);
        got = '0;
        waited = 0;
        len_ok = 1'b0;
        @(negedge clk);
        while (!pin_oe && waited < 40 * P) begin
            @(negedge clk);
            waited++;
        end
        if (!pin_oe) begin
            waited = -1;
        end else begin
            repeat (P / 2) @(negedge clk);
            for (int i = 0; i < nbits; i++) begin
                got[i] = pin_out;
                if (i < nbits - 1) repeat (P) @(negedge clk);
            end
            repeat (P / 2 - 1) @(negedge clk);
            len_ok = pin_oe && tx_busy;
            @(negedge clk);
            len_ok = len_ok && !pin_oe && !tx_busy;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [11:0] got;
        int waited;
        logic len_ok;
        int v0;

        repeat (4) @(posedge clk);
        @(negedge clk);
        // R1: outputs during reset
        chk("R1 oe in reset", int'(pin_oe), 0);
        chk("R1 busy/ready in reset", int'({tx_busy, tx_ready}), 0);
        #1 rst = 1'b0;
        @(negedge clk);
        chk("R1 status after reset", int'({cmd_ready, sec_unlocked, rx_valid, rx_break}), 0);

        // R3: short glitch
        @(posedge clk); #1;
        host_level = 1'b0;
        repeat (P / 4) @(posedge clk);
        #1 host_level = 1'b1;
        repeat (2 * P) @(posedge clk);
        chk("R3 glitch no strobe", valid_cnt + brk_cnt, 0);

        // R11: framing error with nonzero data
        send_bits({2'b11, 1'b0, 8'h5A, 1'b0}, 12);
        repeat (P) @(posedge clk);
        chk("R11 framing error no strobe", valid_cnt + brk_cnt, 0);

        // R9: transmit request during security phase
        @(negedge clk);
        chk("R9 not ready in security", int'(tx_ready), 0);
        tx_data = 8'hC3; tx_start = 1'b1;
        @(negedge clk);
        tx_start = 1'b0;
        repeat (P) @(negedge clk);
        chk("R9 request ignored in security", int'(pin_oe), 0);

        // R2/R5: security bytes from the vector table
        for (int i = 0; i < 7; i++) begin
            v0 = valid_cnt;
            send_byte(SEC_VEC[i]);
            chk("R2 one strobe per byte", valid_cnt - v0, 1);
            chk("R2 received data", int'(last_data), int'(SEC_VEC[i]));
            chk("R5 not ready before eighth", int'(cmd_ready), 0);
        end
        chk("R5 unlocked low before eighth", int'(sec_unlocked), 0);
        key_ok = 1'b1;
        fork
            send_byte(SEC_VEC[7]);
            capture(10, got, waited, len_ok);
        join
        key_ok = 1'b0;
        chk("R2 eighth byte data", int'(last_data), int'(SEC_VEC[7]));
        chk("R6 ready break pattern", int'(got[9:0]), 0);
        chk("R6 ready break length", int'(len_ok), 1);
        chk("R6 ready break follows stop", int'(waited >= 9 * P && waited <= 10 * P), 1);
        chk("R10 no strobe from own break", valid_cnt * 16 + brk_cnt, 8 * 16);
        @(negedge clk);
        chk("R5 ready after announce", int'(cmd_ready), 1);
        chk("R5 key verdict captured", int'(sec_unlocked), 1);

        // R8: monitor transmissions
        for (int i = 0; i < 2; i++) begin
            repeat (2) @(negedge clk);
            chk("R9 ready when idle", int'(tx_ready), 1);
            tx_data = TX_VEC[i]; tx_start = 1'b1;
            fork
                begin
                    @(posedge clk); #1;
                    tx_data = 8'hFF;
                    repeat (3) @(posedge clk); #1;
                    tx_start = 1'b1;
                    @(negedge clk);
                    chk("R9 not ready while busy", int'(tx_ready), 0);
                    tx_start = 1'b0;
                end
                capture(10, got, waited, len_ok);
            join
            tx_start = 1'b0;
            chk("R8 frame bits", int'(got[9:0]), int'({1'b1, TX_VEC[i], 1'b0}));
            chk("R8 oe on next edge", waited, 0);
            chk("R8 frame length", int'(len_ok), 1);
            repeat (2 * P) @(negedge clk);
            chk("R9 busy request dropped", int'(pin_oe), 0);
        end
        chk("R10 no strobe from own frames", valid_cnt * 16 + brk_cnt, 8 * 16);
        chk("R5 key flag held", int'(sec_unlocked), 1);

        // R4/R7: break from host and its answer
        @(posedge clk); #1;
        fork
            send_bits(12'h000, 10);
            capture(12, got, waited, len_ok);
        join
        chk("R4 break strobe", brk_cnt, 1);
        chk("R4 no byte on break", valid_cnt, 8);
        chk("R7 answer pattern", int'(got), 12'h003);
        chk("R7 answer length", int'(len_ok), 1);
        chk("R7 answer timing", int'(waited >= 9 * P + P / 2 && waited <= 9 * P + P / 2 + 8), 1);
        repeat (P) @(negedge clk);
        chk("R7 ready after answer", int'(tx_ready && cmd_ready), 1);

        // R2/R11: command-phase byte and framing error
        send_byte(8'h96);
        chk("R2 command byte", int'(last_data), 8'h96);
        send_bits({2'b11, 1'b0, 8'h01, 1'b0}, 12);
        repeat (P) @(posedge clk);
        chk("R11 no strobe in command phase", valid_cnt * 16 + brk_cnt, 9 * 16 + 1);

        // R1: reset again
        #1 rst = 1'b1;
        repeat (2) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        chk("R1 state cleared", int'({cmd_ready, sec_unlocked, pin_oe, tx_ready}), 0);

        finish_run();
    end
endmodule